// File: doc/BRIEF.md
# Oscillator Failure Monitor with Backup-Clock Switchover

This block watches an external crystal oscillator from the domain of an internal high-frequency backup clock. It counts oscillator edges over a fixed reference window. When armed monitoring sees a window whose count falls outside a programmable band, it declares the oscillator failed. It then steers the high-frequency backup clock onto the oscillator source output, raises a sticky failure flag and, if enabled, requests a device reset. The clock substitution goes through a glitch-free mux. If the oscillator has stopped dead, its enable is removed without waiting for oscillator edges, so the switchover still completes.

After power-on reset the block waits for the high-frequency backup to be declared valid. Monitoring arms when a window shows a good oscillator. If the oscillator never starts, monitoring is forced active after a long timeout counted in low-frequency backup clock edges. Software recovers by setting the oscillator disable bit, which returns the monitor to its unarmed state. When the bit is cleared again, the block re-qualifies the oscillator. A permanently dead crystal simply fails again after the timeout. The control inputs are register bits that are synchronous to the high-frequency backup clock.

Top module: `osc_fail_monitor`

## Requirements
- R1: `hfValid` rises on exactly the 32nd rising edge of `hfClk` after `porN` is released, and it then stays high until the next power-on reset.
- R2: Once `hfValid` is high, `detActive` rises at the end of the first window of `WINDOW` hfClk cycles whose oscillator rising-edge count lies within [`CNT_LO`, `CNT_HI`].
- R3: If no window qualifies, `detActive` rises after `LF_TIMEOUT` rising edges of `lfClk` (16384 by default), counted from the start of unarmed monitoring, and not before.
- R4: While armed, a window whose count is below `CNT_LO` or above `CNT_HI` (including a stopped oscillator) sets `oscSrcInvalid`, and `clkOut` then carries `hfClk` in place of `oscClk`.
- R5: `oscFailFlag` sets on a detected failure. A `clrFail` pulse (write 1) clears it only when `oscSrcInvalid` is low. Neither `oscDisable` nor a `clrFail` during the failure clears it.
- R6: `resetReq` is high while `oscSrcInvalid` is high and `rofEn` is 1. It stays low on a failure when `rofEn` is 0.
- R7: Setting `oscDisable` drops `detActive` and `oscSrcInvalid` within a few cycles. After `oscDisable` is cleared, a good oscillator re-arms monitoring and `clkOut` follows `oscClk` again.
- R8: If the oscillator is re-enabled while still dead, the block arms by timeout and fails again each time, with no lockup.
- R9: `clkOut` never shows a high or low pulse shorter than half an `hfClk` period at any switchover.
- R10: While `porN` is low, `hfValid`, `detActive`, `oscSrcInvalid`, `oscFailFlag` and `resetReq` are all 0.
- R11: With a nominal in-band oscillator and no failure, `clkOut` has the oscillator's edge rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hfClk | input | 1 | High-frequency backup clock; all status logic runs on it |
| lfClk | input | 1 | Low-frequency backup clock, sampled for the startup timeout |
| oscClk | input | 1 | External crystal oscillator clock under supervision |
| porN | input | 1 | Active-low power-on reset, asynchronous |
| oscDisable | input | 1 | Oscillator disable bit; clears the monitor while high |
| rofEn | input | 1 | Reset-on-failure enable bit |
| clrFail | input | 1 | Write-1 pulse that clears the sticky failure flag |
| clkOut | output | 1 | Oscillator source output: oscClk, or hfClk after a failure |
| hfValid | output | 1 | High-frequency backup declared valid |
| detActive | output | 1 | Failure monitoring is armed |
| oscSrcInvalid | output | 1 | Oscillator source currently judged failed |
| oscFailFlag | output | 1 | Sticky oscillator failure flag |
| resetReq | output | 1 | Device reset request on failure |

## Verification
`hfValid` is the only exact-cycle result. It is sampled on the falling edge after the 31st and after the 32nd rising edge following release. The oscillator-driven results land at a window boundary whose phase the bench does not control. Adding the three-flop sampling path and the registered status, they are due within one window plus about four cycles. Checks are therefore made three windows after each stimulus, and edge rates on `clkOut` are counted over a 64-cycle span with a one-edge tolerance. The timeout is checked on both sides of the expected edge count, with one window of slack for the follow-on failure.

// File: rtl/ofd_pkg.sv
`timescale 1ns/1ps
package ofd_pkg;

  typedef enum logic [1:0] {
    ST_INIT   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_ARMED  = 2'd2,
    ST_FAILED = 2'd3
  } detState_t;

  // strobes from control to measurement datapath
  typedef struct packed {
    logic measClr;
    logic tmoRun;
  } ctrlStrobe_t;

  // results from measurement datapath to control
  typedef struct packed {
    logic hfValid;
    logic winEnd;
    logic inRange;
    logic timeoutHit;
  } measStat_t;

endpackage

// File: rtl/ofd_meas.sv
`timescale 1ns/1ps
module ofd_meas
  import ofd_pkg::*;
#(
  parameter int HFV_CYCLES   = 32,
  parameter int WINDOW       = 256,
  parameter int CNT_LO       = 40,
  parameter int CNT_HI       = 88,
  parameter int LF_TIMEOUT   = 16384,
  parameter int STALL_CYCLES = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic        hfClk,
  input  logic        lfClk,
  input  logic        oscClk,
  input  logic        porN,
  input  ctrlStrobe_t cs,
  output measStat_t   ms,
  output logic        oscStalled
);

  localparam int HV_W  = $clog2(HFV_CYCLES + 1);
  localparam int WIN_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam int CNT_W = $clog2(WINDOW + 2);
  localparam int TMO_W = $clog2(LF_TIMEOUT + 1);
  localparam int STL_W = $clog2(STALL_CYCLES + 1);
  localparam int SMP_W = SYNC_STAGES + 1;

  // sampling of the foreign clocks into the hfClk domain
  logic [SMP_W-1:0] oscSamp;
  logic [SMP_W-1:0] lfSamp;

  always_ff @(posedge hfClk or negedge porN) begin
    if (!porN) begin
      oscSamp <= '0;
      lfSamp  <= '0;
    end else begin
      oscSamp <= {oscSamp[SMP_W-2:0], oscClk};
      lfSamp  <= {lfSamp[SMP_W-2:0], lfClk};
    end
  end

  logic oscRise;
  logic oscChange;
  logic lfRise;
  assign oscRise   = oscSamp[SMP_W-2] & ~oscSamp[SMP_W-1];
  assign oscChange = oscSamp[SMP_W-2] ^ oscSamp[SMP_W-1];
  assign lfRise    = lfSamp[SMP_W-2] & ~lfSamp[SMP_W-1];

  // backup clock qualification after power-on
  logic [HV_W-1:0] hfvCnt;
  logic            hfValidQ;

  always_ff @(posedge hfClk or negedge porN) begin
    if (!porN) begin
      hfvCnt   <= '0;
      hfValidQ <= 1'b0;
    end else if (!hfValidQ) begin
      hfvCnt <= hfvCnt + 1'b1;
      if (hfvCnt == HV_W'(HFV_CYCLES - 1)) hfValidQ <= 1'b1;
    end
  end

  // edge count over the reference window
  logic [WIN_W-1:0] winCnt;
  logic [CNT_W-1:0] edgeCnt;
  logic [CNT_W-1:0] winTotal;
  logic             winLast;

  assign winLast  = (winCnt == WIN_W'(WINDOW - 1));
  assign winTotal = edgeCnt + CNT_W'(oscRise);

  always_ff @(posedge hfClk or negedge porN) begin
    if (!porN) begin
      winCnt  <= '0;
      edgeCnt <= '0;
    end else if (cs.measClr) begin
      winCnt  <= '0;
      edgeCnt <= '0;
    end else if (winLast) begin
      winCnt  <= '0;
      edgeCnt <= '0;
    end else begin
      winCnt  <= winCnt + 1'b1;
      edgeCnt <= winTotal;
    end
  end

  // startup timeout in low-frequency edges
  logic [TMO_W-1:0] tmoCnt;

  always_ff @(posedge hfClk or negedge porN) begin
    if (!porN) begin
      tmoCnt <= '0;
    end else if (!cs.tmoRun) begin
      tmoCnt <= '0;
    end else if (lfRise && (tmoCnt != TMO_W'(LF_TIMEOUT))) begin
      tmoCnt <= tmoCnt + 1'b1;
    end
  end

  // dead-oscillator detector for the clock mux
  logic [STL_W-1:0] stallCnt;

  always_ff @(posedge hfClk or negedge porN) begin
    if (!porN) begin
      stallCnt <= '0;
    end else if (oscChange) begin
      stallCnt <= '0;
    end else if (stallCnt != STL_W'(STALL_CYCLES)) begin
      stallCnt <= stallCnt + 1'b1;
    end
  end

  assign oscStalled    = (stallCnt == STL_W'(STALL_CYCLES));
  assign ms.hfValid    = hfValidQ;
  assign ms.winEnd     = winLast & ~cs.measClr;
  assign ms.inRange    = (winTotal >= CNT_W'(CNT_LO)) && (winTotal <= CNT_W'(CNT_HI));
  assign ms.timeoutHit = cs.tmoRun & lfRise & (tmoCnt == TMO_W'(LF_TIMEOUT - 1));

  // R1
  hfvalid_hold_chk: assert property (@(posedge hfClk) disable iff (!porN)
    hfValidQ |=> hfValidQ);

  // R3
  tmo_single_chk: assert property (@(posedge hfClk) disable iff (!porN)
    ms.timeoutHit |=> !ms.timeoutHit);

endmodule

// File: rtl/ofd_ctrl.sv
`timescale 1ns/1ps
module ofd_ctrl
  import ofd_pkg::*;
(
  input  logic        hfClk,
  input  logic        porN,
  input  logic        oscDisable,
  input  logic        rofEn,
  input  logic        clrFail,
  input  measStat_t   ms,
  output ctrlStrobe_t cs,
  output logic        detActive,
  output logic        oscSrcInvalid,
  output logic        oscFailFlag,
  output logic        resetReq,
  output logic        selHf
);

  detState_t state;
  detState_t nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_INIT:   if (ms.hfValid) nextState = ST_WAIT;
      ST_WAIT:   if (!oscDisable && ((ms.winEnd && ms.inRange) || ms.timeoutHit))
                   nextState = ST_ARMED;
      ST_ARMED:  if (oscDisable) nextState = ST_WAIT;
                 else if (ms.winEnd && !ms.inRange) nextState = ST_FAILED;
      ST_FAILED: if (oscDisable) nextState = ST_WAIT;
      default:   nextState = ST_INIT;
    endcase
  end

  logic failPulse;
  assign failPulse = (state == ST_ARMED) && (nextState == ST_FAILED);

  always_ff @(posedge hfClk or negedge porN) begin
    if (!porN) begin
      state       <= ST_INIT;
      oscFailFlag <= 1'b0;
      resetReq    <= 1'b0;
    end else begin
      state    <= nextState;
      resetReq <= (state == ST_FAILED) && rofEn;
      if (failPulse || (state == ST_FAILED)) oscFailFlag <= 1'b1;
      else if (clrFail)                      oscFailFlag <= 1'b0;
    end
  end

  assign cs.measClr    = (state == ST_INIT) || oscDisable;
  assign cs.tmoRun     = (state == ST_WAIT) && !oscDisable;
  assign detActive     = (state == ST_ARMED) || (state == ST_FAILED);
  assign oscSrcInvalid = (state == ST_FAILED);
  assign selHf         = (state == ST_FAILED);

  // R5
  flag_held_chk: assert property (@(posedge hfClk) disable iff (!porN)
    oscSrcInvalid |-> oscFailFlag);

  // R5
  flag_clear_chk: assert property (@(posedge hfClk) disable iff (!porN)
    $fell(oscFailFlag) |-> $past(clrFail));

  // R6
  reset_req_chk: assert property (@(posedge hfClk) disable iff (!porN)
    resetReq |-> ($past(rofEn) && $past(oscSrcInvalid)));

  // R7
  disable_clear_chk: assert property (@(posedge hfClk) disable iff (!porN)
    (oscDisable && ms.hfValid) |=> !detActive);

  // R2
  arm_cause_chk: assert property (@(posedge hfClk) disable iff (!porN)
    $rose(detActive) |-> $past(ms.timeoutHit || (ms.winEnd && ms.inRange)));

endmodule

// File: rtl/ofd_clkmux.sv
`timescale 1ns/1ps
module ofd_clkmux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic hfClk,
  input  logic oscClk,
  input  logic porN,
  input  logic selHf,
  input  logic oscStalled,
  output logic clkOut
);

  logic [SYNC_STAGES-1:0] oscEnSync;
  logic [SYNC_STAGES-1:0] hfEnSync;
  logic                   oscEn;
  logic                   hfEn;
  logic                   killQ;
  logic                   oscKill;

  assign oscEn = oscEnSync[SYNC_STAGES-1];
  assign hfEn  = hfEnSync[SYNC_STAGES-1];

  // a stopped oscillator cannot clock its own enable low
  always_ff @(posedge hfClk or negedge porN) begin
    if (!porN) killQ <= 1'b0;
    else       killQ <= selHf && oscStalled;
  end

  assign oscKill = !porN || killQ;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(negedge oscClk or posedge oscKill) begin
        if (oscKill) oscEnSync <= '0;
        else         oscEnSync <= !selHf && !hfEn;
      end
      always_ff @(negedge hfClk or negedge porN) begin
        if (!porN) hfEnSync <= '0;
        else       hfEnSync <= selHf && !oscEn;
      end
    end else begin : g_multi
      always_ff @(negedge oscClk or posedge oscKill) begin
        if (oscKill) oscEnSync <= '0;
        else         oscEnSync <= {oscEnSync[SYNC_STAGES-2:0], !selHf && !hfEn};
      end
      always_ff @(negedge hfClk or negedge porN) begin
        if (!porN) hfEnSync <= '0;
        else       hfEnSync <= {hfEnSync[SYNC_STAGES-2:0], selHf && !oscEn};
      end
    end
  endgenerate

  assign clkOut = (oscClk & oscEn) | (hfClk & hfEn);

  // R9
  mux_exclusive_chk: assert property (@(posedge hfClk) disable iff (!porN)
    !(oscEn && hfEn));

endmodule

// File: rtl/osc_fail_monitor.sv
`timescale 1ns/1ps
module osc_fail_monitor
  import ofd_pkg::*;
#(
  parameter int HFV_CYCLES   = 32,
  parameter int WINDOW       = 256,
  parameter int CNT_LO       = 40,
  parameter int CNT_HI       = 88,
  parameter int LF_TIMEOUT   = 16384,
  parameter int STALL_CYCLES = 8,
  parameter int SYNC_STAGES  = 2
) (
  input  logic hfClk,
  input  logic lfClk,
  input  logic oscClk,
  input  logic porN,
  input  logic oscDisable,
  input  logic rofEn,
  input  logic clrFail,
  output logic clkOut,
  output logic hfValid,
  output logic detActive,
  output logic oscSrcInvalid,
  output logic oscFailFlag,
  output logic resetReq
);

  ctrlStrobe_t cs;
  measStat_t   ms;
  logic        oscStalled;
  logic        selHf;

  ofd_meas #(
    .HFV_CYCLES  (HFV_CYCLES),
    .WINDOW      (WINDOW),
    .CNT_LO      (CNT_LO),
    .CNT_HI      (CNT_HI),
    .LF_TIMEOUT  (LF_TIMEOUT),
    .STALL_CYCLES(STALL_CYCLES),
    .SYNC_STAGES (SYNC_STAGES)
  ) meas_i (
    .hfClk     (hfClk),
    .lfClk     (lfClk),
    .oscClk    (oscClk),
    .porN      (porN),
    .cs        (cs),
    .ms        (ms),
    .oscStalled(oscStalled)
  );

  ofd_ctrl ctrl_i (
    .hfClk        (hfClk),
    .porN         (porN),
    .oscDisable   (oscDisable),
    .rofEn        (rofEn),
    .clrFail      (clrFail),
    .ms           (ms),
    .cs           (cs),
    .detActive    (detActive),
    .oscSrcInvalid(oscSrcInvalid),
    .oscFailFlag  (oscFailFlag),
    .resetReq     (resetReq),
    .selHf        (selHf)
  );

  ofd_clkmux #(
    .SYNC_STAGES(SYNC_STAGES)
  ) mux_i (
    .hfClk     (hfClk),
    .oscClk    (oscClk),
    .porN      (porN),
    .selHf     (selHf),
    .oscStalled(oscStalled),
    .clkOut    (clkOut)
  );

  assign hfValid = ms.hfValid;

endmodule

// File: tb/osc_fail_monitor_tb.sv
`timescale 1ns/1ps
module osc_fail_monitor_tb_top;

  localparam int WIN  = 32;
  localparam int TMO  = 64;
  localparam int SETTLE = 3 * WIN + 8;

  logic hfClk, lfClk, oscClk, porN, oscDisable, rofEn, clrFail;
  logic clkOut, hfValid, detActive, oscSrcInvalid, oscFailFlag, resetReq;

  int oscMode;      // 0 stopped, 1 nominal, 2 fast, 3 slow
  int testsRun;
  int testsFailed;
  int clkEdges;
  int glitchCnt;
  bit done;
  realtime lastT;

  osc_fail_monitor #(
    .HFV_CYCLES  (32),
    .WINDOW      (WIN),
    .CNT_LO      (6),
    .CNT_HI      (10),
    .LF_TIMEOUT  (TMO),
    .STALL_CYCLES(4),
    .SYNC_STAGES (2)
  ) dut_i (
    .hfClk        (hfClk),
    .lfClk        (lfClk),
    .oscClk       (oscClk),
    .porN         (porN),
    .oscDisable   (oscDisable),
    .rofEn        (rofEn),
    .clrFail      (clrFail),
    .clkOut       (clkOut),
    .hfValid      (hfValid),
    .detActive    (detActive),
    .oscSrcInvalid(oscSrcInvalid),
    .oscFailFlag  (oscFailFlag),
    .resetReq     (resetReq)
  );

  initial begin
    hfClk = 1'b0;
    forever #10 hfClk = ~hfClk;
  end

  initial begin
    lfClk = 1'b0;
    #7;
    forever #80 lfClk = ~lfClk;
  end

  initial begin
    oscClk = 1'b0;
    #3;
    forever begin
      case (oscMode)
        1: begin #40;  oscClk = ~oscClk; end
        2: begin #25;  oscClk = ~oscClk; end
        3: begin #100; oscClk = ~oscClk; end
        default: begin oscClk = 1'b0; #10; end
      endcase
    end
  end

  always @(posedge clkOut) clkEdges++;

  always @(clkOut) begin
    if (porN && lastT > 0.0 && ($realtime - lastT) < 9.0) glitchCnt++;
    lastT = $realtime;
  end

  task automatic chk(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chkRange(input string tag, input int act, input int lo, input int hi);
    testsRun++;
    if (act < lo || act > hi) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge hfClk);
  endtask

  task automatic edgeRate(output int n);
    int start;
    start = clkEdges;
    waitCyc(64);
    n = clkEdges - start;
  endtask

  task automatic pulseClr();
    clrFail = 1'b1;
    waitCyc(1);
    clrFail = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge hfClk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    int n;
    int modes[3];
    modes[0] = 2; modes[1] = 3; modes[2] = 0;
    testsRun = 0; testsFailed = 0; clkEdges = 0; glitchCnt = 0; lastT = 0.0;
    porN = 1'b0; oscDisable = 1'b0; rofEn = 1'b0; clrFail = 1'b0; oscMode = 1;
    waitCyc(5);
    // R10 all status low during reset
    chk("R10 status during reset",
        int'({hfValid, detActive, oscSrcInvalid, oscFailFlag, resetReq}), 0);

    porN = 1'b1;
    waitCyc(31);
    chk("R1 hfValid after 31 edges", int'(hfValid), 0);
    waitCyc(1);
    chk("R1 hfValid after 32 edges", int'(hfValid), 1);

    waitCyc(SETTLE);
    chk("R2 armed on good window", int'(detActive), 1);
    chk("R2 no failure on nominal osc", int'(oscSrcInvalid), 0);
    chk("R1 hfValid held", int'(hfValid), 1);
    edgeRate(n);
    chkRange("R11 clkOut follows osc", n, 15, 17);

    // failure sweep: fast, slow, stopped oscillator
    foreach (modes[i]) begin
      rofEn = (modes[i] == 3);
      oscMode = modes[i];
      waitCyc(SETTLE);
      chk("R4 failure detected", int'(oscSrcInvalid), 1);
      chk("R5 flag set on failure", int'(oscFailFlag), 1);
      chk("R6 reset request matches enable", int'(resetReq), int'(rofEn));
      edgeRate(n);
      chkRange("R4 clkOut carries backup", n, 63, 65);
      pulseClr();
      waitCyc(2);
      chk("R5 clear ignored during failure", int'(oscFailFlag), 1);
      oscDisable = 1'b1;
      waitCyc(4);
      chk("R7 disable clears invalid", int'(oscSrcInvalid), 0);
      chk("R7 disable clears armed", int'(detActive), 0);
      chk("R6 reset request drops", int'(resetReq), 0);
      chk("R5 flag survives disable", int'(oscFailFlag), 1);
      pulseClr();
      waitCyc(2);
      chk("R5 clear after failure", int'(oscFailFlag), 0);
      oscMode = 1;
      waitCyc(8);
      oscDisable = 1'b0;
      waitCyc(SETTLE);
      chk("R7 re-armed after enable", int'(detActive), 1);
      chk("R7 no failure after recovery", int'(oscSrcInvalid), 0);
      edgeRate(n);
      chkRange("R7 clkOut back on osc", n, 15, 17);
    end
    rofEn = 1'b0;

    // hard fault: re-enable with the crystal still dead, twice
    for (int k = 0; k < 2; k++) begin
      oscDisable = 1'b1;
      oscMode = 0;
      waitCyc(4);
      pulseClr();
      oscDisable = 1'b0;
      waitCyc(480);
      chk("R3 no arm before timeout", int'(detActive), 0);
      waitCyc(120);
      chk("R8 dead osc fails again", int'(oscSrcInvalid), 1);
      chk("R8 flag set again", int'(oscFailFlag), 1);
    end
    oscDisable = 1'b1;
    waitCyc(4);
    pulseClr();
    oscMode = 1;
    oscDisable = 1'b0;
    waitCyc(SETTLE);
    chk("R8 recovers once osc runs", int'(detActive), 1);
    chk("R8 healthy after hard fault", int'(oscSrcInvalid), 0);

    // startup with an oscillator that never runs
    porN = 1'b0;
    oscMode = 0;
    waitCyc(4);
    chk("R10 flag cleared by power-on", int'(oscFailFlag), 0);
    porN = 1'b1;
    waitCyc(32 + 480);
    chk("R3 startup not armed early", int'(detActive), 0);
    waitCyc(120);
    chk("R3 startup armed by timeout", int'(detActive), 1);
    chk("R4 startup dead osc fails", int'(oscSrcInvalid), 1);

    chk("R9 no runt pulses on clkOut", glitchCnt, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule